// File: doc/BRIEF.md
# Cycle-Stealing Multi-Channel DMA Controller

This block moves single words between peripheral devices and main memory by taking memory cycles away from the processor. While it owns the memory port it holds the processor in a stall, so the running program pauses and then resumes. It does not take an interrupt, and no processor register changes. Each channel serves one device. A channel keeps no registers of its own. Its remaining-word counter and its running transfer address both sit in memory, at a fixed pair of locations per channel.

A device asks for service by raising its request line, with the direction line set to say which way the word moves. It keeps the request high until its done line pulses. The controller picks the lowest-numbered pending channel, and only while no transfer is running. For that channel it then runs a fixed sequence:

1. Read the counter word and write it back plus one.
2. Read the address word and write it back plus one.
3. Move the data word at that incremented address.

When the counter wraps to zero, the device also receives an overflow pulse. A priority-interrupt grant is given only when no channel wants service.

Top module: `cs_dma`

## Requirements
- R1: Among pending channels, the lowest index wins. The choice is made only while idle. The stall begins on the clock after a request is seen, and its first clock is a read of the winner's counter word.
- R2: A transfer with direction low (device to memory) stalls for exactly 5 clocks: counter read and write, address read and write, then the data write. `ch_done` pulses in the data-write clock.
- R3: A transfer with direction high (memory to device) stalls for exactly 6 clocks: the same four clocks, a data read, then a clock in which `dev_rdata` carries the word and `ch_done` pulses. At all other times `dev_rdata` is zero.
- R4: The counter and address words are each written back as the value just read plus one, modulo 2^DW.
- R5: Channel n keeps its counter at address BASE+2n and its address word at BASE+2n+1.
- R6: The data word is written to, or read from, the low AW bits of the address word after its increment.
- R7: When the counter write-back equals zero, `ch_ovf[n]` is high for one clock, in the clock after `ch_done`. Otherwise it stays low.
- R8: `ch_done` is one-hot or zero, and pulses on the served channel's bit once per transfer.
- R9: `cpu_stall` is high exactly in the clocks the block owns memory. `mem_en` is never high without it, and the stall drops for at least one clock between transfers.
- R10: `pi_grant` follows `pi_req` only while the block is idle and no channel request is pending.
- R11: A request that arrives during a transfer does not preempt it, even from a higher-priority channel.
- R12: In reset, `cpu_stall`, `mem_en`, `ch_done`, `ch_ovf` and `dev_rdata` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | NCH | Per-channel service request, held until done |
| ch_dir | input | NCH | Per-channel direction, 1 = memory to device |
| dev_wdata | input | NCH*DW | Per-channel device word, channel n at bits n*DW upward |
| ch_done | output | NCH | One-clock pulse when the channel's word has moved |
| ch_ovf | output | NCH | One-clock pulse after done when the counter wrapped to zero |
| dev_rdata | output | DW | Word read for a memory-to-device transfer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the clock after a read |
| cpu_stall | output | 1 | Holds the processor while cycles are stolen |
| pi_req | input | 1 | Priority-interrupt request from the interrupt logic |
| pi_grant | output | 1 | Priority-interrupt grant |

## Verification
The bench uses the default parameters: eight channels, 18-bit words, 15-bit addresses and a state base of zero. With eight channels, requests from both ends of the priority chain can collide, and a late request on channel 0 can arrive during channel 7's transfer. The 18-bit width lets a counter preset to all ones, or stepped up to it, reach the wrap to zero within a few transfers. A state base of zero keeps every touched location inside a small memory model.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CNT_RD,
      ST_CNT_WR,
      ST_ADR_RD,
      ST_ADR_WR,
      ST_XFER,
      ST_PRESENT
   } step_t;
endpackage

// File: rtl/csdma_arb.sv
module csdma_arb #(
   parameter int NCH = 8,
   localparam int IW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any_req,
   output logic [IW-1:0]  win_idx
);
   logic [NCH-1:0] win;

   for (genvar i = 0; i < NCH; i++) begin : g_pri
      if (i == 0) begin : g_head
         assign win[i] = req[i];
      end else begin : g_tail
         assign win[i] = req[i] & ~|req[i-1:0];
      end
   end

   assign any_req = |req;

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NCH; i++) begin
         if (win[i]) win_idx = IW'(i);
      end
   end
endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
   import csdma_pkg::*;
#(
   parameter int NCH = 8,
   localparam int IW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           any_req,
   input  logic [IW-1:0]  win_idx,
   input  logic [NCH-1:0] ch_dir,
   output step_t          step,
   output logic [IW-1:0]  cur_ch,
   output logic           cur_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step    <= ST_IDLE;
         cur_ch  <= '0;
         cur_out <= 1'b0;
      end else begin
         case (step)
            ST_IDLE: begin
               if (any_req) begin
                  cur_ch  <= win_idx;
                  cur_out <= ch_dir[win_idx];
                  step    <= ST_CNT_RD;
               end
            end
            ST_CNT_RD:  step <= ST_CNT_WR;
            ST_CNT_WR:  step <= ST_ADR_RD;
            ST_ADR_RD:  step <= ST_ADR_WR;
            ST_ADR_WR:  step <= ST_XFER;
            ST_XFER:    step <= cur_out ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: step <= ST_IDLE;
            default:    step <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/csdma_dp.sv
module csdma_dp
   import csdma_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int DW   = 18,
   parameter int AW   = 15,
   parameter int BASE = 0,
   localparam int IW  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_t             step,
   input  logic [IW-1:0]     cur_ch,
   input  logic              cur_out,
   input  logic [NCH*DW-1:0] dev_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW-1:0]     dev_rdata,
   output logic [NCH-1:0]    ch_done,
   output logic [NCH-1:0]    ch_ovf
);
   logic [DW-1:0] bumped;
   logic [AW-1:0] cnt_loc;
   logic [AW-1:0] adr_loc;
   logic [AW-1:0] xfer_addr;
   logic          wrap_seen;
   logic          ovf_fire;
   logic          last_step;

   assign bumped    = mem_rdata + DW'(1);
   assign cnt_loc   = AW'(BASE) + AW'({cur_ch, 1'b0});
   assign adr_loc   = cnt_loc + AW'(1);
   assign last_step = (step == ST_XFER && !cur_out) || (step == ST_PRESENT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_addr <= '0;
         wrap_seen <= 1'b0;
         ovf_fire  <= 1'b0;
      end else begin
         if (step == ST_CNT_WR) wrap_seen <= (bumped == '0);
         if (step == ST_ADR_WR) xfer_addr <= bumped[AW-1:0];
         ovf_fire <= last_step && wrap_seen;
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (step)
         ST_CNT_RD: begin
            mem_en   = 1'b1;
            mem_addr = cnt_loc;
         end
         ST_CNT_WR: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cnt_loc;
            mem_wdata = bumped;
         end
         ST_ADR_RD: begin
            mem_en   = 1'b1;
            mem_addr = adr_loc;
         end
         ST_ADR_WR: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = adr_loc;
            mem_wdata = bumped;
         end
         ST_XFER: begin
            mem_en    = 1'b1;
            mem_we    = !cur_out;
            mem_addr  = xfer_addr;
            mem_wdata = cur_out ? '0 : dev_wdata[cur_ch*DW +: DW];
         end
         default: ;
      endcase
   end

   assign dev_rdata = (step == ST_PRESENT) ? mem_rdata : '0;
   assign ch_done   = last_step ? (NCH'(1) << cur_ch) : '0;
   assign ch_ovf    = ovf_fire ? (NCH'(1) << cur_ch) : '0;
endmodule

// File: rtl/cs_dma.sv
module cs_dma
   import csdma_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int DW   = 18,
   parameter int AW   = 15,
   parameter int BASE = 0,
   localparam int IW  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    ch_req,
   input  logic [NCH-1:0]    ch_dir,
   input  logic [NCH*DW-1:0] dev_wdata,
   output logic [NCH-1:0]    ch_done,
   output logic [NCH-1:0]    ch_ovf,
   output logic [DW-1:0]     dev_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              cpu_stall,
   input  logic              pi_req,
   output logic              pi_grant
);
   initial begin
      assert (NCH >= 2) else $error("cs_dma: NCH must be at least 2");
      assert (DW >= AW) else $error("cs_dma: DW must hold an address");
      assert (BASE % 2 == 0) else $error("cs_dma: BASE must be even");
      assert (BASE + 2 * NCH <= (1 << AW)) else $error("cs_dma: state block exceeds memory");
   end

   logic          any_req;
   logic [IW-1:0] win_idx;
   logic [IW-1:0] cur_ch;
   logic          cur_out;
   step_t         step;

   csdma_arb #(.NCH(NCH)) u_arb (
      .req     (ch_req),
      .any_req (any_req),
      .win_idx (win_idx)
   );

   csdma_seq #(.NCH(NCH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_req (any_req),
      .win_idx (win_idx),
      .ch_dir  (ch_dir),
      .step    (step),
      .cur_ch  (cur_ch),
      .cur_out (cur_out)
   );

   csdma_dp #(.NCH(NCH), .DW(DW), .AW(AW), .BASE(BASE)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .cur_ch    (cur_ch),
      .cur_out   (cur_out),
      .dev_wdata (dev_wdata),
      .mem_rdata (mem_rdata),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .dev_rdata (dev_rdata),
      .ch_done   (ch_done),
      .ch_ovf    (ch_ovf)
   );

   assign cpu_stall = (step != ST_IDLE);
   assign pi_grant  = pi_req && !cpu_stall && !any_req;
endmodule

// File: rtl/csdma_chk.sv
module csdma_chk #(
   parameter int NCH = 8,
   parameter int DW  = 18,
   parameter int AW  = 15
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] ch_req,
   input logic [NCH-1:0] ch_done,
   input logic [NCH-1:0] ch_ovf,
   input logic           mem_en,
   input logic           mem_we,
   input logic [AW-1:0]  mem_addr,
   input logic [DW-1:0]  mem_wdata,
   input logic [DW-1:0]  mem_rdata,
   input logic           cpu_stall,
   input logic           pi_grant
);
   assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stall |-> !mem_en);

   assert_bump_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && $past(mem_en && !mem_we) && mem_addr == $past(mem_addr))
      |-> mem_wdata == DW'(mem_rdata + DW'(1)));

   assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_done));

   assert_ovf_follows_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ovf != '0) |-> $past(ch_done) == ch_ovf);

   assert_pi_yields_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pi_grant |-> (!cpu_stall && ch_req == '0));

   assert_stall_ends_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall) |-> $past(ch_done) != '0);

   assert_start_count_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> (mem_en && !mem_we && !mem_addr[0]));

   assert_start_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> $past(ch_req) != '0);
endmodule

bind cs_dma csdma_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/cs_dma_test.sv
module cs_dma_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 18;
   localparam int AW  = 15;

   typedef struct {
      int            ch;
      bit            out;
      logic [DW-1:0] data;
      bit            ovf;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    ch_req = '0;
   logic [NCH-1:0]    ch_dir = '0;
   logic [NCH*DW-1:0] dev_wdata = '0;
   logic [NCH-1:0]    ch_done, ch_ovf;
   logic [DW-1:0]     dev_rdata;
   logic              mem_en, mem_we;
   logic [AW-1:0]     mem_addr;
   logic [DW-1:0]     mem_wdata;
   logic [DW-1:0]     mem_rdata = '0;
   logic              cpu_stall;
   logic              pi_req = 1'b0;
   logic              pi_grant;

   logic [DW-1:0] mem [0:255];
   item_t         sb[$];
   int            checks = 0;
   int            errors = 0;
   int            stall_cnt = 0;
   bit            ovf_due = 0;
   int            ovf_ch = 0;
   bit            ovf_exp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_dma uut (.*);

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on each done pulse; device model drops its request there.
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cpu_stall || !mem_en, "R9 memory idle outside stall", {31'd0, mem_en}, 32'd0);
         if (cpu_stall) stall_cnt++;
         if (ovf_due) begin
            chk(ch_ovf == (ovf_exp ? NCH'(1) << ovf_ch : NCH'(0)), "R7 overflow pulse", ch_ovf, ovf_exp ? (1 << ovf_ch) : 0);
            chk(!cpu_stall, "R9 stall gap between transfers", cpu_stall, 0);
            ovf_due = 0;
         end else begin
            chk(ch_ovf == '0, "R7 no stray overflow", ch_ovf, 0);
         end
         if (ch_done != '0) begin
            if (sb.size() == 0) begin
               chk(0, "R8 unexpected done", ch_done, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               chk(ch_done == NCH'(1) << it.ch, "R8 R1 done channel order", ch_done, 1 << it.ch);
               if (it.out) begin
                  chk(dev_rdata == it.data, "R3 output word", dev_rdata, it.data);
                  chk(stall_cnt == 6, "R3 output stall length", stall_cnt, 6);
               end else begin
                  chk(stall_cnt == 5, "R2 input stall length", stall_cnt, 5);
               end
               ch_req[it.ch] = 1'b0;
               ovf_due = 1;
               ovf_ch  = it.ch;
               ovf_exp = it.ovf;
            end
            stall_cnt = 0;
         end else begin
            chk(dev_rdata == '0, "R3 device data idle", dev_rdata, 0);
         end
      end
   end

   task automatic launch(input int c, input bit out, input logic [DW-1:0] word,
                         input logic [DW-1:0] exp_rd, input bit exp_ovf);
      item_t it;
      it.ch = c; it.out = out; it.data = exp_rd; it.ovf = exp_ovf;
      sb.push_back(it);
      dev_wdata[c*DW +: DW] = word;
      ch_dir[c] = out;
      ch_req[c] = 1'b1;
   endtask

   task automatic drain();
      wait (ch_req == '0);
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_mem(input int a, input logic [DW-1:0] exp, input string tag);
      chk(mem[a] === exp, tag, mem[a], exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int n = 0; n < NCH; n++) begin
         mem[2*n]   = 18'h3FFFD;
         mem[2*n+1] = DW'(32'h40 + 16*n);
      end
      mem[6]    = 18'h3FFFF;
      mem[8'h91] = 18'h2A5A5;
      mem[8'h81] = 18'h01234;

      repeat (3) @(negedge clk);
      chk(!cpu_stall && !mem_en && ch_done == '0 && ch_ovf == '0 && dev_rdata == '0,
          "R12 reset outputs", {cpu_stall, mem_en, ch_done, ch_ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Input on channel 2.
      launch(2, 0, 18'h15555, '0, 0);
      drain();
      chk_mem(8'h61, 18'h15555, "R6 input word at bumped address");
      chk_mem(4, 18'h3FFFE, "R4 counter bumped");
      chk_mem(5, 18'h00061, "R5 R4 address word bumped");

      // Output on channel 5.
      launch(5, 1, '0, 18'h2A5A5, 0);
      drain();
      chk_mem(10, 18'h3FFFE, "R5 channel 5 counter");
      chk_mem(11, 18'h00091, "R4 channel 5 address");

      // Priority: 1 and 6 together, 1 first.
      launch(1, 0, 18'h00111, '0, 0);
      launch(6, 0, 18'h00666, '0, 0);
      drain();
      chk_mem(8'h51, 18'h00111, "R1 channel 1 word");
      chk_mem(8'hA1, 18'h00666, "R1 channel 6 word");

      // No preemption: 0 arrives during 7.
      launch(7, 0, 18'h00777, '0, 0);
      repeat (2) @(negedge clk);
      launch(0, 0, 18'h000AA, '0, 0);
      drain();
      chk_mem(8'hB1, 18'h00777, "R11 channel 7 word");
      chk_mem(8'h41, 18'h000AA, "R11 channel 0 word");

      // Counter wrap on channel 3.
      launch(3, 0, 18'h00333, '0, 1);
      drain();
      chk_mem(6, 18'h00000, "R7 counter wrapped");
      chk_mem(8'h71, 18'h00333, "R6 channel 3 word");

      // Channel 2 again, then wrap on the next one.
      launch(2, 0, 18'h00222, '0, 0);
      drain();
      launch(2, 0, 18'h00223, '0, 1);
      drain();
      chk_mem(8'h62, 18'h00222, "R6 consecutive address");
      chk_mem(8'h63, 18'h00223, "R6 consecutive address second");
      chk_mem(4, 18'h00000, "R7 channel 2 counter wrapped");

      // Interrupt grant yields to channel service.
      pi_req = 1'b1;
      #1;
      chk(pi_grant, "R10 grant while idle", pi_grant, 1);
      launch(4, 1, '0, 18'h01234, 0);
      #1;
      chk(!pi_grant, "R10 no grant with request", pi_grant, 0);
      @(negedge clk);
      chk(!pi_grant && cpu_stall, "R10 no grant in stall", {pi_grant, cpu_stall}, 1);
      drain();
      chk(pi_grant, "R10 grant after transfer", pi_grant, 1);
      pi_req = 1'b0;

      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R8 all transfers done", sb.size(), 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule